// File: doc/BRIEF.md
# Gated Seconds Digit Display

This block turns a fast system clock into a once-per-second strobe and shows a running hexadecimal seconds count on a single common-anode seven-segment digit. The strobe leaves the block as a one-cycle pulse, so a neighbouring alarm controller can time its entry delay from it. The same strobe advances a 4-bit digit counter.

The digit counter is gated by a run request from that controller. While the request is high, the digit steps through 0 to F and then wraps. While it is low, the digit is held at zero, so every new delay starts its count from 0. The counter value is decoded into active-low segment drive, and a fixed active-low anode pattern enables the rightmost of four digit positions.

The divide ratio, the counter widths, the segment polarity, the anode polarity and the chosen digit position are all parameters. The defaults give a 5 MHz input clock, a 1 Hz strobe and a 28-bit divider.

Top module: `sec_digit_display`

## Requirements
- R1: `tick_o` is high for exactly one clock cycle at a time. Two successive pulses are exactly `CLK_HZ/TICK_HZ` cycles apart, which is 5,000,000 with the defaults.
- R2: Reset clears the divider. The first pulse after reset release appears in the `CLK_HZ/TICK_HZ`-th clock cycle counted from the first cycle without reset, when the divider reaches its last value and wraps.
- R3: While `run_i` is 1, the digit increases by one in the cycle after each `tick_o` pulse. It holds its value in every other cycle.
- R4: While `run_i` is 0, the digit becomes 0 at the next clock edge and stays 0, whether or not a pulse occurs.
- R5: The digit wraps from F to 0 on the next pulse while `run_i` is 1.
- R6: The bit layout of `seg_n_o` is active low. Bit 7 is segment A, bits 6 down to 1 are segments B to G, and bit 0 is the decimal point. The codes for digits 0 to F are 03, 9F, 25, 0D, 99, 49, 41, 1F, 01, 09, 11, C1, 63, 85, 61, 71 (hex).
- R7: The decimal point is never lit, so bit 0 of `seg_n_o` is always 1.
- R8: `anode_n_o` is 4'b1110 at all times. It enables only the rightmost digit, active low.
- R9: Synchronous reset clears the digit. During and right after reset, `seg_n_o` reads 03 and `tick_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | Run request from the alarm controller; 0 clears the digit |
| tick_o | output | 1 | One-cycle strobe at the divided rate |
| seg_n_o | output | 8 | Active-low segments, A at bit 7 through G at bit 1, decimal point at bit 0 |
| anode_n_o | output | 4 | Active-low digit enables |

## Verification
The bench builds the block with `CLK_HZ=10` and `TICK_HZ=1`, so one strobe period is ten cycles rather than five million. At that ratio a full 0-to-F wrap, many run drops at random phases of the divider, and resets in the middle of a period all fit in a few thousand cycles. The divider width keeps its default of 28 bits, so the wrap comparison works on a full-width register even with the short count.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

   localparam int unsigned SEG_W   = 8;
   localparam int unsigned HEX_W   = 4;

   typedef logic [SEG_W-1:0] seg_t;
   typedef logic [HEX_W-1:0] hex_t;

   // Lit segments, active high: bit 7 = A ... bit 1 = G, bit 0 = decimal point.
   function automatic seg_t hex_to_lit(input hex_t v);
      seg_t s;
      case (v)
         4'h0: s = 8'hFC;
         4'h1: s = 8'h60;
         4'h2: s = 8'hDA;
         4'h3: s = 8'hF2;
         4'h4: s = 8'h66;
         4'h5: s = 8'hB6;
         4'h6: s = 8'hBE;
         4'h7: s = 8'hE0;
         4'h8: s = 8'hFE;
         4'h9: s = 8'hF6;
         4'hA: s = 8'hEE;
         4'hB: s = 8'h3E;
         4'hC: s = 8'h9C;
         4'hD: s = 8'h7A;
         4'hE: s = 8'h9E;
         default: s = 8'h8E;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/sdd_tick_div.sv
module sdd_tick_div #(
   parameter int unsigned DIV_COUNT = 5_000_000,
   parameter int unsigned DIV_W     = 28
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic tick_o
);
   localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV_COUNT - 1);

   if (DIV_COUNT < 2) begin : g_bad_ratio
      $error("sdd_tick_div: DIV_COUNT must be at least 2");
   end
   if ($clog2(DIV_COUNT) > DIV_W) begin : g_bad_width
      $error("sdd_tick_div: DIV_W too narrow for DIV_COUNT");
   end

   logic [DIV_W-1:0] cnt_q;
   logic             at_last;

   assign at_last = (cnt_q == LAST);

   always_ff @(posedge clk_i) begin
      if (rst_i)        cnt_q <= '0;
      else if (at_last) cnt_q <= '0;
      else              cnt_q <= cnt_q + DIV_W'(1);
   end

   assign tick_o = at_last;
endmodule

// File: rtl/sdd_digit_ctr.sv
module sdd_digit_ctr #(
   parameter int unsigned DIGIT_W = 4
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               run_i,
   input  logic               tick_i,
   output logic [DIGIT_W-1:0] digit_o
);
   logic [DIGIT_W-1:0] digit_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || !run_i) digit_q <= '0;
      else if (tick_i)     digit_q <= digit_q + DIGIT_W'(1);
   end

   assign digit_o = digit_q;
endmodule

// File: rtl/sdd_seg_decode.sv
module sdd_seg_decode
   import sdd_pkg::*;
#(
   parameter bit SEG_ACTIVE_LOW = 1'b1
) (
   input  hex_t hex_i,
   output seg_t seg_o
);
   seg_t lit;

   always_comb lit = hex_to_lit(hex_i);

   if (SEG_ACTIVE_LOW) begin : g_low
      assign seg_o = ~lit;
   end else begin : g_high
      assign seg_o = lit;
   end
endmodule

// File: rtl/sdd_anode_drv.sv
module sdd_anode_drv #(
   parameter int unsigned ANODE_N          = 4,
   parameter int unsigned ACTIVE_DIGIT     = 0,
   parameter bit          ANODE_ACTIVE_LOW = 1'b1
) (
   output logic [ANODE_N-1:0] anode_o
);
   if (ACTIVE_DIGIT >= ANODE_N) begin : g_bad_sel
      $error("sdd_anode_drv: ACTIVE_DIGIT out of range");
   end

   for (genvar i = 0; i < ANODE_N; i++) begin : g_pos
      localparam bit ON = (i == ACTIVE_DIGIT);
      if (ANODE_ACTIVE_LOW) begin : g_low
         assign anode_o[i] = ~ON;
      end else begin : g_high
         assign anode_o[i] = ON;
      end
   end
endmodule

// File: rtl/sec_digit_display.sv
module sec_digit_display
   import sdd_pkg::*;
#(
   parameter int unsigned CLK_HZ           = 5_000_000,
   parameter int unsigned TICK_HZ          = 1,
   parameter int unsigned DIV_W            = 28,
   parameter int unsigned DIGIT_W          = 4,
   parameter int unsigned ANODE_N          = 4,
   parameter int unsigned ACTIVE_DIGIT     = 0,
   parameter bit          SEG_ACTIVE_LOW   = 1'b1,
   parameter bit          ANODE_ACTIVE_LOW = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               run_i,
   output logic               tick_o,
   output logic [SEG_W-1:0]   seg_n_o,
   output logic [ANODE_N-1:0] anode_n_o
);
   localparam int unsigned DIV_COUNT = CLK_HZ / TICK_HZ;

   if (TICK_HZ == 0 || TICK_HZ > CLK_HZ) begin : g_bad_rate
      $error("sec_digit_display: TICK_HZ must be in 1..CLK_HZ");
   end
   if (DIGIT_W != HEX_W) begin : g_bad_digit
      $error("sec_digit_display: DIGIT_W must equal the decoder width");
   end

   logic               tick;
   logic [DIGIT_W-1:0] digit_q;

   sdd_tick_div #(
      .DIV_COUNT (DIV_COUNT),
      .DIV_W     (DIV_W)
   ) u_div (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .tick_o (tick)
   );

   sdd_digit_ctr #(
      .DIGIT_W (DIGIT_W)
   ) u_ctr (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .run_i   (run_i),
      .tick_i  (tick),
      .digit_o (digit_q)
   );

   sdd_seg_decode #(
      .SEG_ACTIVE_LOW (SEG_ACTIVE_LOW)
   ) u_dec (
      .hex_i (digit_q),
      .seg_o (seg_n_o)
   );

   sdd_anode_drv #(
      .ANODE_N          (ANODE_N),
      .ACTIVE_DIGIT     (ACTIVE_DIGIT),
      .ANODE_ACTIVE_LOW (ANODE_ACTIVE_LOW)
   ) u_an (
      .anode_o (anode_n_o)
   );

   assign tick_o = tick;
endmodule

// File: rtl/sdd_checker.sv
module sdd_checker #(
   parameter int unsigned DIV_COUNT = 5_000_000,
   parameter int unsigned DIGIT_W   = 4
) (
   input logic               clk_i,
   input logic               rst_i,
   input logic               run_i,
   input logic               tick_i,
   input logic [7:0]         seg_n_i,
   input logic [DIGIT_W-1:0] digit_i
);
   logic [31:0] gap_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)       gap_q <= '0;
      else if (tick_i) gap_q <= '0;
      else             gap_q <= gap_q + 32'd1;
   end

   AST_TICK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
      tick_i |=> !tick_i);                                              // R1
   AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (rst_i)
      tick_i |-> (gap_q == DIV_COUNT - 1));                             // R2
   AST_GAP_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
      gap_q < DIV_COUNT);                                               // R1
   AST_DIGIT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
      (run_i && tick_i) |=> (digit_i == DIGIT_W'($past(digit_i) + 1))); // R3
   AST_DIGIT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      (run_i && !tick_i) |=> $stable(digit_i));                         // R3
   AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      !run_i |=> (seg_n_i == 8'h03));                                   // R4
   AST_RESET_ZERO: assert property (@(posedge clk_i)
      rst_i |=> (seg_n_i == 8'h03 && !tick_i));                         // R9
endmodule

bind sec_digit_display sdd_checker #(
   .DIV_COUNT (DIV_COUNT),
   .DIGIT_W   (DIGIT_W)
) u_sdd_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .run_i   (run_i),
   .tick_i  (tick_o),
   .seg_n_i (seg_n_o),
   .digit_i (digit_q)
);

// File: tb/sec_digit_display_tb_top.sv
module sec_digit_display_tb_top;
   localparam int unsigned CLK_HZ  = 10;
   localparam int unsigned TICK_HZ = 1;
   localparam int unsigned PERIOD  = CLK_HZ / TICK_HZ;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       run = 1'b0;
   logic       tick;
   logic [7:0] seg_n;
   logic [3:0] anode_n;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   int unsigned m_cnt = 0;
   int unsigned m_dig = 0;
   int unsigned seed  = 32'h5eed_1234;

   always #5ns clk = ~clk;

   sec_digit_display #(
      .CLK_HZ  (CLK_HZ),
      .TICK_HZ (TICK_HZ)
   ) dut_i (
      .clk_i     (clk),
      .rst_i     (rst),
      .run_i     (run),
      .tick_o    (tick),
      .seg_n_o   (seg_n),
      .anode_n_o (anode_n)
   );

   function automatic logic [7:0] exp_seg(input int unsigned d);
      case (d & 15)
         0: return 8'h03;  1: return 8'h9F;  2: return 8'h25;  3: return 8'h0D;
         4: return 8'h99;  5: return 8'h49;  6: return 8'h41;  7: return 8'h1F;
         8: return 8'h01;  9: return 8'h09;  10: return 8'h11; 11: return 8'hC1;
         12: return 8'h63; 13: return 8'h85; 14: return 8'h61; default: return 8'h71;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Advance the model across the edge just passed, using the inputs held there.
   task automatic model_step();
      bit t;
      t = (m_cnt == PERIOD - 1);
      if (rst) begin
         m_cnt = 0; m_dig = 0;
      end else begin
         if (!run)   m_dig = 0;
         else if (t) m_dig = (m_dig + 1) % 16;
         m_cnt = t ? 0 : m_cnt + 1;
      end
   endtask

   task automatic cycle(input bit nrst, input bit nrun);
      @(negedge clk);
      model_step();
      chk("R1/R2 tick", {7'b0, tick}, {7'b0, (m_cnt == PERIOD - 1)});
      chk("R3/R4/R5/R6 seg", seg_n, exp_seg(m_dig));
      chk("R7 dp off", {7'b0, seg_n[0]}, 8'h01);
      chk("R8 anode", {4'b0, anode_n}, 8'h0E);
      rst = nrst;
      run = nrun;
   endtask

   initial begin
      #2ms;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R9: reset state
      @(negedge clk);
      rst = 1'b1; run = 1'b1;
      repeat (3) cycle(1'b1, 1'b1);
      chk("R9 reset seg", seg_n, 8'h03);
      chk("R9 reset tick", {7'b0, tick}, 8'h00);
      // R2: first pulse in the PERIOD-th cycle after release
      cycle(1'b0, 1'b1);
      for (int i = 0; i < PERIOD - 1; i++) cycle(1'b0, 1'b1);
      chk("R2 first tick", {7'b0, tick}, 8'h01);
      // R3/R5: run through a full wrap
      for (int i = 0; i < PERIOD * 17; i++) cycle(1'b0, 1'b1);
      // R4: run dropped across a pulse keeps digit zero
      for (int i = 0; i < PERIOD * 2; i++) cycle(1'b0, 1'b0);
      chk("R4 idle seg", seg_n, 8'h03);
      // Mixed random run/reset
      for (int i = 0; i < 4000; i++) begin
         int unsigned r;
         r = $urandom(seed);
         seed = r;
         cycle((r % 97) == 0, (r % 10) != 0);
      end
      // R5: long run ending near wrap
      for (int i = 0; i < PERIOD * 20; i++) cycle(1'b0, 1'b1);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule